// File: doc/BRIEF.md
# Upset-Tolerant Four-Phase Sequencer

This block is a small control sequencer whose state register is built to survive single-event bit flips. It steps through four phases (idle, load, run, done) under two request inputs. Instead of a plain two-bit binary value, the phase is held as a six-bit single-error-correcting, double-error-detecting Hamming code word. Every cycle the stored word is decoded and corrected, and a freshly encoded word is written back. A single flipped bit is therefore repaired at the next clock edge without disturbing the sequence.

Any word that cannot be corrected is treated as the idle phase. A frame sync strobe also forces idle, so a corrupted state lasts at most one frame and never needs an external reset to clear. The sequencer uses exactly four phases, so every two-bit value has a meaning and none is left unused.

A test-only mask input XORs bits into the word being stored, so that upsets can be produced on purpose. Two flags report that a correction happened, or that an error was detected but could not be corrected.

Top module: `upset_tolerant_fsm`

## Requirements
- R1: A synchronous active-high reset stores the encoded idle word. On the cycle after reset, `phase_out` is 0 (idle) and both error flags are low.
- R2: In idle (phase code 0), the sequencer moves to load (code 1) on the edge where `start_req` is high. Otherwise it stays idle.
- R3: Load (code 1) always moves to run (code 2) on the next edge.
- R4: Run (code 2) holds while `finish_req` is low and moves to done (code 3) on the edge where `finish_req` is high.
- R5: Done (code 3) always returns to idle on the next edge.
- R6: A high `frame_sync` at an edge forces idle on the next cycle, whatever the current phase. It takes priority over `start_req` and `finish_req`.
- R7: The phases 0, 1, 2 and 3 are stored as the words 6'h00, 6'h0F, 6'h33 and 6'h3C. Bit 0 of each word is the overall parity, and bits 1 to 5 are Hamming positions 1 to 5. A `flip_mask` with exactly one bit set, present at an edge, corrupts the stored word for the following cycle. In that cycle `phase_out` still shows the correct phase and `corrected_err` is high. The sequence then carries on as if no flip had occurred.
- R8: A `flip_mask` with exactly two bits set, present at an edge, corrupts the stored word for the following cycle. In that cycle `uncorrectable_err` is high, `phase_out` reads idle, and the next phase is idle regardless of the requests.
- R9: `corrected_err` and `uncorrectable_err` are never high together. Both stay low in every cycle that follows an edge with a zero `flip_mask`.
- R10: A `flip_mask` present at an edge where reset is high has no effect. The stored word is the clean idle word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | Frame strobe that forces idle |
| start_req | input | 1 | Request to leave idle for load |
| finish_req | input | 1 | Request to leave run for done |
| flip_mask | input | 6 | Test-only mask XORed into the stored word at an edge |
| phase_out | output | 2 | Decoded phase: 0 idle, 1 load, 2 run, 3 done |
| corrected_err | output | 1 | A single-bit error was corrected this cycle |
| uncorrectable_err | output | 1 | A double-bit error was detected this cycle |

## Verification
The hardest situation to reach from the ports is a corrupted stored word in a chosen phase, with requests asserted that would otherwise move the sequencer. Upsets cannot happen in simulation on their own, so the bench walks the sequencer into each phase and drives `flip_mask` at that edge. It uses every single-bit mask and several two-bit pairs, and raises `start_req`, `finish_req` or `frame_sync` in the corrupted cycle. A behavioural model tracks the logical phase and the pending mask, and compares all outputs on every clock. This shows that corrections are invisible to the sequence and that detections collapse it to idle.

// File: rtl/ftsm_pkg.sv
package ftsm_pkg;

    localparam int PH_W  = 2;
    localparam int PAR_W = 3;
    localparam int POS_N = PH_W + PAR_W;
    localparam int CW_W  = POS_N + 1;

    typedef enum logic [PH_W-1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_RUN  = 2'd2,
        PH_DONE = 2'd3
    } phase_t;

    typedef logic [CW_W-1:0] cword_t;

    typedef struct packed {
        phase_t phase;
        logic   fixed;
        logic   fatal;
    } dec_t;

    function automatic logic is_pow2(input int p);
        return (p & (p - 1)) == 0;
    endfunction

    function automatic cword_t hm_encode(input phase_t ph);
        cword_t w;
        logic [PH_W-1:0] d;
        int di;
        logic x;
        w  = '0;
        d  = ph;
        di = 0;
        for (int p = 1; p <= POS_N; p++) begin
            if (!is_pow2(p)) begin
                w[p] = d[di];
                di++;
            end
        end
        for (int k = 0; k < PAR_W; k++) begin
            x = 1'b0;
            for (int p = 1; p <= POS_N; p++) begin
                if (p[k]) x = x ^ w[p];
            end
            w[1 << k] = x;
        end
        w[0] = ^w[CW_W-1:1];
        return w;
    endfunction

    function automatic logic [PAR_W-1:0] hm_syndrome(input cword_t w);
        logic [PAR_W-1:0] s;
        s = '0;
        for (int k = 0; k < PAR_W; k++) begin
            for (int p = 1; p <= POS_N; p++) begin
                if (p[k]) s[k] = s[k] ^ w[p];
            end
        end
        return s;
    endfunction

    function automatic logic [PH_W-1:0] hm_extract(input cword_t w);
        logic [PH_W-1:0] d;
        int di;
        d  = '0;
        di = 0;
        for (int p = 1; p <= POS_N; p++) begin
            if (!is_pow2(p)) begin
                d[di] = w[p];
                di++;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/ftsm_decoder.sv
module ftsm_decoder
    import ftsm_pkg::*;
(
    input  cword_t word_i,
    output dec_t   dec_o
);

    logic [PAR_W-1:0] syn;
    logic             odd;
    cword_t           fixed_w;
    logic             single;
    logic             multi;

    always_comb begin
        syn     = hm_syndrome(word_i);
        odd     = ^word_i;
        fixed_w = word_i;
        single  = 1'b0;
        multi   = 1'b0;
        if (odd) begin
            if (int'(syn) <= POS_N) begin
                fixed_w[syn] = ~word_i[syn];
                single       = 1'b1;
            end else begin
                multi = 1'b1;
            end
        end else if (syn != '0) begin
            multi = 1'b1;
        end
        dec_o.fixed = single;
        dec_o.fatal = multi;
        dec_o.phase = multi ? PH_IDLE : phase_t'(hm_extract(fixed_w));
    end

endmodule

// File: rtl/ftsm_sequencer.sv
module ftsm_sequencer
    import ftsm_pkg::*;
(
    input  dec_t   cur_i,
    input  logic   frame_sync,
    input  logic   start_req,
    input  logic   finish_req,
    output phase_t next_o
);

    always_comb begin
        next_o = cur_i.phase;
        if (frame_sync || cur_i.fatal) begin
            next_o = PH_IDLE;
        end else begin
            unique case (cur_i.phase)
                PH_IDLE: next_o = start_req  ? PH_LOAD : PH_IDLE;
                PH_LOAD: next_o = PH_RUN;
                PH_RUN:  next_o = finish_req ? PH_DONE : PH_RUN;
                PH_DONE: next_o = PH_IDLE;
                default: next_o = PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ftsm_store.sv
module ftsm_store
    import ftsm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  phase_t  next_i,
    input  cword_t  flip_i,
    output cword_t  word_o
);

    cword_t enc;

    always_comb enc = hm_encode(next_i);

    always_ff @(posedge clk) begin
        if (rst) word_o <= hm_encode(PH_IDLE);
        else     word_o <= enc ^ flip_i;
    end

    // R1 / R10: reset leaves the clean idle word regardless of the mask
    p_reset_clean_r10: assert property (@(posedge clk)
        rst |=> word_o == hm_encode(PH_IDLE));

    // R9: a zero mask always stores a valid code word
    p_clean_store_r9: assert property (@(posedge clk) disable iff (rst)
        flip_i == '0 |=> (hm_syndrome(word_o) == '0 && !(^word_o)));

endmodule

// File: rtl/upset_tolerant_fsm.sv
module upset_tolerant_fsm
    import ftsm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_sync,
    input  logic       start_req,
    input  logic       finish_req,
    input  logic [5:0] flip_mask,
    output logic [1:0] phase_out,
    output logic       corrected_err,
    output logic       uncorrectable_err
);

    cword_t word;
    dec_t   cur;
    phase_t nxt;

    ftsm_decoder u_dec (
        .word_i (word),
        .dec_o  (cur)
    );

    ftsm_sequencer u_seq (
        .cur_i      (cur),
        .frame_sync (frame_sync),
        .start_req  (start_req),
        .finish_req (finish_req),
        .next_o     (nxt)
    );

    ftsm_store u_store (
        .clk    (clk),
        .rst    (rst),
        .next_i (nxt),
        .flip_i (flip_mask),
        .word_o (word)
    );

    assign phase_out         = cur.phase;
    assign corrected_err     = cur.fixed;
    assign uncorrectable_err = cur.fatal;

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (phase_out == 2'd0 && !corrected_err && !uncorrectable_err));

    p_load_run_r3: assert property (@(posedge clk) disable iff (rst)
        (phase_out == 2'd1 && !frame_sync) |=> (phase_out == 2'd2 || uncorrectable_err));

    p_done_idle_r5: assert property (@(posedge clk) disable iff (rst)
        phase_out == 2'd3 |=> phase_out == 2'd0);

    p_sync_idle_r6: assert property (@(posedge clk) disable iff (rst)
        frame_sync |=> phase_out == 2'd0);

    p_fatal_idle_r8: assert property (@(posedge clk) disable iff (rst)
        uncorrectable_err |-> phase_out == 2'd0);

    p_fatal_recover_r8: assert property (@(posedge clk) disable iff (rst)
        (uncorrectable_err && flip_mask == 6'd0) |=> (phase_out == 2'd0 && !uncorrectable_err));

    p_flags_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(corrected_err && uncorrectable_err));

    p_fix_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        (corrected_err && flip_mask == 6'd0) |=> !corrected_err);

endmodule

// File: tb/test_upset_tolerant_fsm.sv
module test_upset_tolerant_fsm;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_sync = 1'b0;
    logic       start_req = 1'b0;
    logic       finish_req = 1'b0;
    logic [5:0] flip_mask = 6'd0;
    logic [1:0] phase_out;
    logic       corrected_err;
    logic       uncorrectable_err;

    always #10 clk = ~clk;

    upset_tolerant_fsm i_upset_tolerant_fsm (
        .clk               (clk),
        .rst               (rst),
        .frame_sync        (frame_sync),
        .start_req         (start_req),
        .finish_req        (finish_req),
        .flip_mask         (flip_mask),
        .phase_out         (phase_out),
        .corrected_err     (corrected_err),
        .uncorrectable_err (uncorrectable_err)
    );

    int         checks = 0;
    int         errors = 0;
    int         m_ph   = 0;
    logic [5:0] m_mask = 6'd0;
    bit         finished = 0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // one clock: drive, advance the model, compare after the edge
    task automatic cyc(input string tag, input bit r, input bit s, input bit st,
                       input bit fi, input logic [5:0] m);
        int cnt;
        int nxt;
        @(negedge clk);
        rst = r; frame_sync = s; start_req = st; finish_req = fi; flip_mask = m;
        @(posedge clk);
        cnt = $countones(m_mask);
        if (s || cnt == 2) nxt = 0;
        else begin
            case (m_ph)
                0: nxt = st ? 1 : 0;
                1: nxt = 2;
                2: nxt = fi ? 3 : 2;
                default: nxt = 0;
            endcase
        end
        if (r) begin m_ph = 0; m_mask = 6'd0; end
        else   begin m_ph = nxt; m_mask = m; end
        #5;
        cnt = $countones(m_mask);
        chk(tag, "phase", int'(phase_out), (cnt == 2) ? 0 : m_ph);
        chk(tag, "corrected", int'(corrected_err), (cnt == 1) ? 1 : 0);
        chk(tag, "uncorrectable", int'(uncorrectable_err), (cnt == 2) ? 1 : 0);
    endtask

    task automatic go_to(input int ph);
        cyc("R6", 0, 1, 0, 0, 6'd0);
        if (ph >= 1) cyc("R2", 0, 0, 1, 0, 6'd0);
        if (ph >= 2) cyc("R3", 0, 0, 0, 0, 6'd0);
        if (ph >= 3) cyc("R4", 0, 0, 0, 1, 6'd0);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset
        cyc("R1", 1, 0, 0, 0, 6'd0);
        cyc("R1", 1, 0, 0, 0, 6'd0);
        cyc("R1", 0, 0, 0, 0, 6'd0);
        // R2 idle holds, then start
        cyc("R2", 0, 0, 0, 1, 6'd0);
        cyc("R2", 0, 0, 1, 0, 6'd0);
        cyc("R3", 0, 0, 1, 1, 6'd0);
        cyc("R4", 0, 0, 1, 0, 6'd0);
        cyc("R4", 0, 0, 0, 0, 6'd0);
        cyc("R4", 0, 0, 0, 1, 6'd0);
        cyc("R5", 0, 0, 1, 1, 6'd0);
        cyc("R9", 0, 0, 0, 0, 6'd0);
        // R6 frame sync in each phase and against requests
        for (int ph = 0; ph < 4; ph++) begin
            go_to(ph);
            cyc("R6", 0, 1, 1, 1, 6'd0);
            cyc("R6", 0, 0, 0, 0, 6'd0);
        end
        // R7 single flips in every phase at every bit
        for (int ph = 0; ph < 4; ph++) begin
            for (int b = 0; b < 6; b++) begin
                go_to(ph);
                cyc("R7", 0, 0, 0, 0, 6'(1 << b));
                cyc("R7", 0, 0, 1, 1, 6'd0);
                cyc("R7", 0, 0, 1, 0, 6'd0);
            end
        end
        // R8 double flips, requests asserted in the corrupted cycle
        for (int ph = 0; ph < 4; ph++) begin
            for (int a = 0; a < 5; a++) begin
                for (int b = a + 1; b < 6; b++) begin
                    go_to(ph);
                    cyc("R8", 0, 0, 0, 0, 6'((1 << a) | (1 << b)));
                    cyc("R8", 0, 0, 1, 1, 6'd0);
                    cyc("R8", 0, 0, 0, 0, 6'd0);
                end
            end
        end
        // back-to-back flips and flip with frame sync
        go_to(2);
        cyc("R7", 0, 0, 0, 0, 6'h04);
        cyc("R8", 0, 0, 0, 1, 6'h21);
        cyc("R8", 0, 1, 1, 0, 6'h10);
        cyc("R7", 0, 0, 1, 0, 6'd0);
        // R10 mask at reset is ignored
        go_to(3);
        cyc("R10", 1, 0, 0, 0, 6'h3F);
        cyc("R10", 1, 0, 1, 0, 6'h01);
        cyc("R10", 0, 0, 0, 0, 6'd0);
        cyc("R9", 0, 0, 1, 0, 6'd0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule